// File: doc/BRIEF.md
# Three-Stage Queued Pipeline for a Two-Instruction Machine

This block is a small in-order processor core built as three stages: instruction fetch, operand read, and execute with writeback. Between each pair of stages sits a one-entry holding slot with a presence flag. All stages step on the same clock edge. The core holds a program counter, eight 8-bit registers and a 256-word instruction store.

The machine has two instructions. One increments a register. The other jumps to a target address when a register reads zero. A taken jump redirects the counter and discards whatever the two slots hold. Operand read waits while the execute slot still holds an increment of the register it needs. Fetch waits when its slot is full and is not being drained.

Software fills the instruction store through a write port while reset is held low. A combinational register view lets the surrounding logic read any register.

Top module: `qp_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter becomes 0, both slot presence flags clear, and all eight registers become 0.
- R2: A write to the instruction store (`load_en` high) takes effect only at an edge where `rst_n` is low. A write made while `rst_n` is high changes nothing that is later fetched.
- R3: The instruction word is 12 bits. Bit 11 is the opcode, with 0 meaning increment and 1 meaning jump-if-zero. Bits 10:8 select the register. Bits 7:0 are the jump target, and an increment ignores them.
- R4: An increment writes the operand value plus one, modulo 256, into its register. The write happens at the edge that ends its execute cycle.
- R5: With no stall, fetch reads the store at the counter each cycle, fills the first slot, and adds one to the counter. So k edges after reset is released, the counter reads k.
- R6: If the execute slot holds an increment to the same register that the first slot's instruction names, operand read does not take that instruction in this cycle. The counter and the first slot then hold their values.
- R7: A jump-if-zero that reads zero loads the counter with its target at the end of its execute cycle and empties both slots in that same edge. The redirect wins over the normal increment.
- R8: A jump-if-zero that reads a nonzero value does not redirect. Execution falls through to the next address.
- R9: The first slot is never overwritten while it holds an instruction that has not been consumed or flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; store writes allowed only while low |
| load_en | input | 1 | Instruction store write strobe |
| load_addr | input | 8 | Instruction store write address |
| load_data | input | 12 | Instruction word to write |
| dbg_sel | input | 3 | Register index for the observation read |
| dbg_val | output | 8 | Current contents of the selected register |
| pc | output | 8 | Program counter |
| fetch_valid | output | 1 | Presence flag of the fetch-to-operand slot |
| operand_valid | output | 1 | Presence flag of the operand-to-execute slot |

## Verification
The assertions are disabled during reset. They assume the instruction store holds defined words at every address fetch can reach, including wrong-path addresses after a jump. To meet this, the bench writes every one of the 256 locations during each reset. Unused locations hold a jump-to-self on register 7, which never changes. The store-write strobe is toggled only on falling edges. Its single write with reset high checks that such a write has no visible effect. The register view is read only after the outputs have settled, between edges.

// File: rtl/qp_pkg.sv
`timescale 1ns/1ps
// Shared widths, opcode encoding and slot payload types for the pipeline.
package qp_pkg;
    parameter int REG_W  = 3;
    parameter int DATA_W = 8;
    parameter int PC_W   = 8;
    localparam int NREG       = 2 ** REG_W;
    localparam int IMEM_DEPTH = 2 ** PC_W;
    localparam int INSTR_W    = 1 + REG_W + PC_W;

    typedef enum logic { OP_INC = 1'b0, OP_JZ = 1'b1 } op_e;

    // Fetched instruction: opcode in the top bit, register next, target lowest.
    typedef struct packed {
        op_e               op;
        logic [REG_W-1:0]  rsel;
        logic [PC_W-1:0]   tgt;
    } instr_t;

    // Operand slot payload: instruction plus the register value it read.
    typedef struct packed {
        op_e               op;
        logic [REG_W-1:0]  rsel;
        logic [DATA_W-1:0] val;
        logic [PC_W-1:0]   tgt;
    } opnd_t;
endpackage

// File: rtl/qp_fetch.sv
`timescale 1ns/1ps
// Fetch stage: owns the instruction store, the program counter and the
// fetch-to-operand slot. Assumes take/jump_tgt and q1_pop come from the
// start-of-cycle state of the later stages.
module qp_fetch
    import qp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [PC_W-1:0]     load_addr,
    input  logic [INSTR_W-1:0]  load_data,
    input  logic                take,
    input  logic [PC_W-1:0]     jump_tgt,
    input  logic                q1_pop,
    output logic [PC_W-1:0]     pc,
    output logic                q1_valid,
    output instr_t              q1_instr
);
    logic [INSTR_W-1:0] imem [IMEM_DEPTH];
    logic               fetch_go;

    // Fetch proceeds when the slot is free, being drained, or flushed.
    assign fetch_go = !q1_valid || q1_pop || take;

    // Store writes are accepted only while the core is held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n && load_en) imem[load_addr] <= load_data;
    end

    // Counter and slot update: redirect first, then normal fetch, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            q1_valid <= 1'b0;
            q1_instr <= '0;
        end else if (take) begin
            pc       <= jump_tgt;
            q1_valid <= 1'b0;
        end else if (fetch_go) begin
            pc       <= pc + 1'b1;
            q1_valid <= 1'b1;
            q1_instr <= instr_t'(imem[pc]);
        end
    end

    a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !q1_valid) |=> (pc == PC_W'($past(pc) + 1'b1)));

    a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pc == $past(jump_tgt) && !q1_valid));

    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (q1_valid && !q1_pop && !take) |=> (q1_valid && $stable(q1_instr) && $stable(pc)));
endmodule

// File: rtl/qp_opfetch.sv
`timescale 1ns/1ps
// Operand stage: moves the fetch slot into the execute slot with the value
// read from the register file, stalling on a pending increment of the same
// register. Assumes the execute stage drains its slot every cycle.
module qp_opfetch
    import qp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q1_valid,
    input  instr_t             q1_instr,
    input  logic               take,
    input  logic [DATA_W-1:0]  rf_data,
    output logic [REG_W-1:0]   rf_addr,
    output logic               q1_pop,
    output logic               q2_valid,
    output opnd_t              q2
);
    logic raw_hit;

    // Read-after-write hazard against the increment waiting in execute.
    assign raw_hit = q2_valid && (q2.op == OP_INC) && (q2.rsel == q1_instr.rsel);
    assign q1_pop  = q1_valid && !raw_hit && !take;
    assign rf_addr = q1_instr.rsel;

    // Execute slot load: filled when the head advances, otherwise emptied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q2_valid <= 1'b0;
            q2       <= '0;
        end else if (q1_pop) begin
            q2_valid <= 1'b1;
            q2       <= '{op: q1_instr.op, rsel: q1_instr.rsel,
                          val: rf_data, tgt: q1_instr.tgt};
        end else begin
            q2_valid <= 1'b0;
        end
    end

    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (q1_valid && q2_valid && q2.op == OP_INC && q2.rsel == q1_instr.rsel) |=> !q2_valid);

    a_r7_flush_exec_slot: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !q2_valid);
endmodule

// File: rtl/qp_exec.sv
`timescale 1ns/1ps
// Execute stage and register file: retires the execute slot each cycle,
// writing increments and deciding jumps. Assumes the slot payload carries
// the register value as of operand read.
module qp_exec
    import qp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q2_valid,
    input  opnd_t              q2,
    input  logic [REG_W-1:0]   rf_addr,
    input  logic [REG_W-1:0]   dbg_sel,
    output logic [DATA_W-1:0]  rf_data,
    output logic [DATA_W-1:0]  dbg_val,
    output logic               take,
    output logic [PC_W-1:0]    jump_tgt
);
    logic [DATA_W-1:0] rf [NREG];
    logic              wr_en;

    assign wr_en    = q2_valid && (q2.op == OP_INC);
    assign take     = q2_valid && (q2.op == OP_JZ) && (q2.val == '0);
    assign jump_tgt = q2.tgt;
    assign rf_data  = rf[rf_addr];
    assign dbg_val  = rf[dbg_sel];

    // Register file: cleared in reset, incremented value written on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
        end else if (wr_en) begin
            rf[q2.rsel] <= q2.val + 1'b1;
        end
    end

    a_r4_inc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q2_valid && q2.op == OP_INC) |=>
            (rf[$past(q2.rsel)] == DATA_W'($past(q2.val) + 1'b1)));

    a_r8_no_redirect_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (q2_valid && q2.op == OP_JZ && q2.val != '0) |-> !take);
endmodule

// File: rtl/qp_core.sv
`timescale 1ns/1ps
// Top of the three-stage pipeline: wires fetch, operand read and execute.
// Assumes the instruction store is loaded while rst_n is low.
module qp_core
    import qp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [PC_W-1:0]     load_addr,
    input  logic [INSTR_W-1:0]  load_data,
    input  logic [REG_W-1:0]    dbg_sel,
    output logic [DATA_W-1:0]   dbg_val,
    output logic [PC_W-1:0]     pc,
    output logic                fetch_valid,
    output logic                operand_valid
);
    instr_t            q1_instr;
    opnd_t             q2;
    logic              q1_pop, take;
    logic [PC_W-1:0]   jump_tgt;
    logic [REG_W-1:0]  rf_addr;
    logic [DATA_W-1:0] rf_data;

    qp_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .take(take), .jump_tgt(jump_tgt),
        .q1_pop(q1_pop), .pc(pc), .q1_valid(fetch_valid), .q1_instr(q1_instr)
    );

    qp_opfetch u_opfetch (
        .clk(clk), .rst_n(rst_n), .q1_valid(fetch_valid), .q1_instr(q1_instr),
        .take(take), .rf_data(rf_data), .rf_addr(rf_addr), .q1_pop(q1_pop),
        .q2_valid(operand_valid), .q2(q2)
    );

    qp_exec u_exec (
        .clk(clk), .rst_n(rst_n), .q2_valid(operand_valid), .q2(q2),
        .rf_addr(rf_addr), .dbg_sel(dbg_sel), .rf_data(rf_data),
        .dbg_val(dbg_val), .take(take), .jump_tgt(jump_tgt)
    );
endmodule

// File: tb/test_qp_core.sv
`timescale 1ns/1ps
module test_qp_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [11:0] load_data = '0;
    logic [2:0]  dbg_sel = '0;
    logic [7:0]  dbg_val, pc;
    logic        fetch_valid, operand_valid;
    int          checks = 0, errors = 0;
    logic [11:0] img [256];

    always #2.5 clk = ~clk;

    qp_core i_qp_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_sel(dbg_sel), .dbg_val(dbg_val), .pc(pc),
        .fetch_valid(fetch_valid), .operand_valid(operand_valid)
    );

    // R3 encoding: bit 11 opcode (0 inc, 1 jz), 10:8 register, 7:0 target.
    function automatic logic [11:0] enc_inc(input logic [2:0] r);
        return {1'b0, r, 8'h5A};
    endfunction
    function automatic logic [11:0] enc_jz(input logic [2:0] r, input logic [7:0] t);
        return {1'b1, r, t};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_is(input string req, input int r, input int exp);
        dbg_sel = 3'(r);
        #0.5;
        chk(req, int'(dbg_val), exp);
    endtask

    // Default image: every word jumps to itself on register 7 (stays zero).
    task automatic clear_img();
        for (int a = 0; a < 256; a++) img[a] = enc_jz(3'd7, 8'(a));
    endtask

    // Hold reset, write the whole store, release reset on a falling edge.
    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < 256; a++) begin
            load_en = 1'b1; load_addr = 8'(a); load_data = img[a];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_img();
        img[0] = enc_inc(3'd1);
        boot();
        chk("R1 pc after reset", int'(pc), 0);
        chk("R1 fetch slot empty", int'(fetch_valid), 0);
        chk("R1 operand slot empty", int'(operand_valid), 0);
        for (int r = 0; r < 8; r++) reg_is("R1 register cleared", r, 0);
    endtask

    task automatic t_straight();
        clear_img();
        img[0] = enc_inc(3'd1); img[1] = enc_inc(3'd2); img[2] = enc_inc(3'd3);
        boot();
        step(1);
        chk("R5 pc after 1 edge", int'(pc), 1);
        chk("R5 fetch slot filled", int'(fetch_valid), 1);
        step(1);
        chk("R5 pc after 2 edges", int'(pc), 2);
        chk("R5 operand slot filled", int'(operand_valid), 1);
        step(1);
        chk("R5 pc after 3 edges", int'(pc), 3);
        step(20);
        reg_is("R4 inc r1", 1, 1);
        reg_is("R4 inc r2", 2, 1);
        reg_is("R3 inc r3 ignores target bits", 3, 1);
    endtask

    task automatic t_load_ignored();
        // Store at 3 is the halt loop; an accepted write would run inc r4.
        @(negedge clk);
        load_en = 1'b1; load_addr = 8'd3; load_data = enc_inc(3'd4);
        @(negedge clk);
        load_en = 1'b0;
        step(20);
        reg_is("R2 write with reset high ignored", 4, 0);
        reg_is("R2 other state kept", 1, 1);
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst_n = 1'b0;
        step(1);
        chk("R1 pc cleared by reset", int'(pc), 0);
        reg_is("R1 r1 cleared by reset", 1, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_raw_stall();
        clear_img();
        img[0] = enc_inc(3'd1); img[1] = enc_inc(3'd1); img[2] = enc_inc(3'd1);
        boot();
        step(3);
        chk("R6 pc holds during stall", int'(pc), 2);
        chk("R6 fetch slot kept", int'(fetch_valid), 1);
        chk("R6 operand slot drained", int'(operand_valid), 0);
        step(1);
        chk("R6 pc resumes", int'(pc), 3);
        step(20);
        reg_is("R6 three dependent incs", 1, 3);
    endtask

    task automatic t_taken();
        clear_img();
        img[0] = enc_jz(3'd0, 8'd5); img[1] = enc_inc(3'd2);
        img[2] = enc_inc(3'd3); img[5] = enc_inc(3'd5);
        boot();
        step(2);
        chk("R7 pc before jump", int'(pc), 2);
        step(1);
        chk("R7 pc redirected", int'(pc), 5);
        chk("R7 fetch slot flushed", int'(fetch_valid), 0);
        chk("R7 operand slot flushed", int'(operand_valid), 0);
        step(20);
        reg_is("R7 wrong path r2 untouched", 2, 0);
        reg_is("R7 wrong path r3 untouched", 3, 0);
        reg_is("R7 target path ran", 5, 1);
    endtask

    task automatic t_not_taken();
        clear_img();
        img[0] = enc_inc(3'd1); img[1] = enc_jz(3'd1, 8'd5);
        img[2] = enc_inc(3'd2); img[5] = enc_inc(3'd6);
        boot();
        step(5);
        chk("R8 no redirect after nonzero jz", int'(pc), 4);
        step(20);
        reg_is("R8 fall through ran", 2, 1);
        reg_is("R8 target not ran", 6, 0);
        reg_is("R6 jz saw pending inc", 1, 1);
    endtask

    task automatic t_wrap();
        clear_img();
        img[0] = enc_inc(3'd1); img[1] = enc_jz(3'd1, 8'd3);
        img[2] = enc_jz(3'd0, 8'd0); img[3] = enc_inc(3'd2);
        boot();
        step(4000);
        reg_is("R4 wrap 255 to 0", 1, 0);
        reg_is("R4 loop exit after wrap", 2, 1);
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_straight();
        t_load_ignored();
        t_reset_clears();
        t_raw_stall();
        t_taken();
        t_not_taken();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule